// File: doc/BRIEF.md
# Interrupt IN Endpoint Control Register

This block is the processor-side control and status register for one interrupt IN endpoint of a USB device, together with the packet buffer and the handshake logic behind it. Firmware sees one byte-wide register and a byte push port. It fills the buffer with a packet, programs the packet size limit, and then raises a ready flag. The serial interface engine watches a response code, pops bytes, and reports the host acknowledgement. The block then drops the ready flag, advances the data toggle and raises a sticky interrupt request so that firmware can load the next packet.

Firmware can also empty the buffer, which cancels any pending packet. It can force the data toggle back to DATA0. It can hold the endpoint in a stalled state, in which every IN transaction is answered with STALL. If no acknowledgement arrives, the packet and the toggle are left as they are, and a new IN token rewinds the read pointer so that the same bytes are sent again.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset the ready flag, toggle, stall flag, size limit, buffer count and interrupt are all 0. The register reads 0x00, `resp` is NAK (0) and `tx_len` is 0.
- R2: With `reg_addr` equal to REG_ADDR (0xF2), `reg_rdata` is {0, size[3:0], 0, stall, ready}. Bits 7 and 2 always read 0. Any other address reads 0x00, and writes to other addresses change nothing.
- R3: Write bits 6:3 set the 4-bit packet size limit (in units of 8 bytes). The limit keeps its value until the next register write.
- R4: Writing 1 to bit 7 sets the toggle to DATA0. This takes effect even when an acknowledgement arrives in the same cycle.
- R5: Writing 1 to bit 2 empties the buffer and clears ready. This wins over a bit 0 set in the same write.
- R6: Bit 1 is stored on every register write. While it is 1, `resp` is STALL (1), and acknowledgements and pops are ignored.
- R7: When the endpoint is not stalled, `resp` is NAK (0) if ready is 0. If ready is 1, `resp` is DATA0 (2) when the toggle is 0 and DATA1 (3) when the toggle is 1.
- R8: An acknowledgement while ready is 1 and the endpoint is not stalled clears ready, inverts the toggle, empties the buffer and rewinds the read pointer. An acknowledgement while ready is 0 has no effect.
- R9: `tx_len` is the smaller of the buffer count and 8×size. `tx_data` is the byte at the read pointer, or 0 once the pointer reaches `tx_len`. A pop advances the pointer only while the pointer is below `tx_len`. `tok_in` rewinds the pointer to 0.
- R10: A buffer push is ignored while ready is 1 or while the buffer holds FIFO_DEPTH (64) bytes.
- R11: `irq` goes to 1 in the cycle after an effective acknowledgement and stays there until `irq_ack`. If both arrive together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| fifo_wr | input | 1 | Buffer push strobe |
| fifo_wdata | input | 8 | Buffer push byte |
| tok_in | input | 1 | IN token seen; rewinds read pointer |
| tx_pop | input | 1 | Engine consumes one byte |
| host_ack | input | 1 | Host acknowledgement received |
| resp | output | 2 | 0 NAK, 1 STALL, 2 DATA0, 3 DATA1 |
| tx_data | output | 8 | Byte at read pointer |
| tx_len | output | 7 | Bytes in the packet to send |
| irq_ack | input | 1 | Clears the interrupt request |
| irq | output | 1 | Sticky interrupt request |

## Verification
The embedded properties assume that every input is known and sampled only at the clock edge. They also assume that strobes such as `host_ack` and `tok_in` are single-cycle events. They do not assume that the strobes are mutually exclusive, so acknowledgements, flushes and toggle clears may land in the same cycle. The stimulus drives all inputs on the falling edge, to known values only, and mostly aims register traffic at 0xF2. Stray addresses, and acknowledgements while ready is 0 or while stalled, are kept at a low rate so that they still occur.

// File: rtl/usb_in_ep_pkg.sv
// Shared types for the interrupt IN endpoint control block.
// Assumes the register layout is fixed at 8 bits with a 4-bit size field.
package usb_in_ep_pkg;
    localparam int SIZE_W = 4;

    typedef enum logic [1:0] {
        RESP_NAK   = 2'd0,
        RESP_STALL = 2'd1,
        RESP_DATA0 = 2'd2,
        RESP_DATA1 = 2'd3
    } resp_e;
endpackage

// File: rtl/ep_ctl_regs.sv
// Control state of the endpoint: ready flag, toggle, stall, size limit, irq.
// Assumes wr_en is already qualified by address; ack_fire already gated.
module ep_ctl_regs
    import usb_in_ep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              ack_fire,
    input  logic              irq_ack,
    output logic              rdy,
    output logic              tog,
    output logic              stall,
    output logic [SIZE_W-1:0] size,
    output logic              irq,
    output logic              flush
);
    logic set_rdy;
    logic clr_tog;

    assign flush   = wr_en & wdata[2];
    assign set_rdy = wr_en & wdata[0];
    assign clr_tog = wr_en & wdata[7];

    // Ready flag: engine acknowledge or flush clear it, firmware sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                rdy <= 1'b0;
        else if (ack_fire || flush) rdy <= 1'b0;
        else if (set_rdy)          rdy <= 1'b1;
    end

    // Data toggle: forced clear beats the flip on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        tog <= 1'b0;
        else if (clr_tog)  tog <= 1'b0;
        else if (ack_fire) tog <= ~tog;
    end

    // Stall flag and size limit are plain stored fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall <= 1'b0;
            size  <= '0;
        end else if (wr_en) begin
            stall <= wdata[1];
            size  <= wdata[6:3];
        end
    end

    // Sticky interrupt request, set has priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (ack_fire) irq <= 1'b1;
        else if (irq_ack)  irq <= 1'b0;
    end

    AST_FLUSH_WINS:   assert property (@(posedge clk) disable iff (!rst_n) flush |=> !rdy);              // R5
    AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_tog |=> !tog);            // R4
    AST_IRQ_ON_ACK:   assert property (@(posedge clk) disable iff (!rst_n) ack_fire |=> irq);            // R11
    AST_STALL_HELD:   assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(stall));   // R6
    AST_SIZE_HELD:    assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(size));    // R3
endmodule

// File: rtl/ep_tx_fifo.sv
// Packet buffer: firmware pushes bytes, engine pops them up to the length limit.
// Assumes clear and rewind come from the control logic; pop is gated outside.
module ep_tx_fifo
    import usb_in_ep_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         rdy,
    input  logic                         clear,
    input  logic                         rewind,
    input  logic                         pop,
    input  logic [SIZE_W-1:0]            size,
    output logic [DATA_W-1:0]            tx_data,
    output logic [$clog2(DEPTH+1)-1:0]   tx_len
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AW    = $clog2(DEPTH);
    localparam int LIM_W = SIZE_W + 3;
    localparam int CMP_W = (CNT_W > LIM_W) ? CNT_W : LIM_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  rd_ptr;
    logic [CMP_W-1:0]  cnt_x;
    logic [CMP_W-1:0]  lim_x;
    logic              push_ok;
    logic              pop_ok;

    assign push_ok = push && !rdy && (cnt < CNT_W'(DEPTH));
    assign cnt_x   = CMP_W'(cnt);
    assign lim_x   = CMP_W'({size, 3'b000});
    assign tx_len  = (cnt_x < lim_x) ? cnt : lim_x[CNT_W-1:0];
    assign pop_ok  = pop && (rd_ptr < tx_len);
    assign tx_data = (rd_ptr < tx_len) ? mem[rd_ptr[AW-1:0]] : '0;

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[cnt[AW-1:0]] <= push_data;
    end

    // Fill count: cleared on flush or delivery, grows on accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (push_ok)    cnt <= cnt + 1'b1;
    end

    // Read pointer: rewound per token, advanced per pop within the packet.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || rewind) rd_ptr <= '0;
        else if (pop_ok)               rd_ptr <= rd_ptr + 1'b1;
    end

    AST_NO_PUSH_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n) (rdy && !clear) |=> $stable(cnt));  // R10
    AST_CLEAR_EMPTIES:      assert property (@(posedge clk) disable iff (!rst_n) clear |=> (cnt == '0));             // R8
    AST_PTR_REWIND:         assert property (@(posedge clk) disable iff (!rst_n) rewind |=> (rd_ptr == '0));         // R9
endmodule

// File: rtl/ep_resp_sel.sv
// Chooses the handshake for an IN token from stall, ready and toggle.
// Assumes inputs are registered state; output is combinational.
module ep_resp_sel
    import usb_in_ep_pkg::*;
(
    input  logic  stall,
    input  logic  rdy,
    input  logic  tog,
    output resp_e resp
);
    // Priority: stall, then not ready, then data with current toggle.
    always_comb begin
        if (stall)     resp = RESP_STALL;
        else if (!rdy) resp = RESP_NAK;
        else if (tog)  resp = RESP_DATA1;
        else           resp = RESP_DATA0;
    end
endmodule

// File: rtl/usb_in_ep_ctrl.sv
// Top of the interrupt IN endpoint: register decode, buffer and handshake.
// Assumes a single register at REG_ADDR and single-cycle engine strobes.
module usb_in_ep_ctrl
    import usb_in_ep_pkg::*;
#(
    parameter logic [7:0] REG_ADDR   = 8'hF2,
    parameter int         FIFO_DEPTH = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [7:0]                        reg_addr,
    input  logic                              reg_wr,
    input  logic [7:0]                        reg_wdata,
    output logic [7:0]                        reg_rdata,
    input  logic                              fifo_wr,
    input  logic [7:0]                        fifo_wdata,
    input  logic                              tok_in,
    input  logic                              tx_pop,
    input  logic                              host_ack,
    output logic [1:0]                        resp,
    output logic [7:0]                        tx_data,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   tx_len,
    input  logic                              irq_ack,
    output logic                              irq
);
    logic              sel;
    logic              wr_en;
    logic              rdy;
    logic              tog;
    logic              stall;
    logic [SIZE_W-1:0] size;
    logic              flush;
    logic              ack_fire;
    logic              pop_en;
    resp_e             resp_q;

    assign sel      = (reg_addr == REG_ADDR);
    assign wr_en    = reg_wr && sel;
    assign ack_fire = host_ack && rdy && !stall;
    assign pop_en   = tx_pop && rdy && !stall;

    ep_ctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wdata    (reg_wdata),
        .ack_fire (ack_fire),
        .irq_ack  (irq_ack),
        .rdy      (rdy),
        .tog      (tog),
        .stall    (stall),
        .size     (size),
        .irq      (irq),
        .flush    (flush)
    );

    ep_tx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_wr),
        .push_data (fifo_wdata),
        .rdy       (rdy),
        .clear     (flush || ack_fire),
        .rewind    (tok_in),
        .pop       (pop_en),
        .size      (size),
        .tx_data   (tx_data),
        .tx_len    (tx_len)
    );

    ep_resp_sel u_resp (
        .stall (stall),
        .rdy   (rdy),
        .tog   (tog),
        .resp  (resp_q)
    );

    assign resp = resp_q;

    // Read mux: control bits 7 and 2 always read as zero.
    always_comb begin
        reg_rdata = 8'h00;
        if (sel) reg_rdata = {1'b0, size, 1'b0, stall, rdy};
    end

    AST_STALL_RESP: assert property (@(posedge clk) disable iff (!rst_n) stall |-> (resp == 2'd1));   // R6
    AST_ACK_FLIPS:  assert property (@(posedge clk) disable iff (!rst_n)
                        (ack_fire && !(wr_en && reg_wdata[7])) |=> (tog != $past(tog)));            // R8
    AST_NAK_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) (!stall && !rdy) |-> (resp == 2'd0)); // R7
endmodule

// File: tb/usb_in_ep_ctrl_tb_top.sv
module usb_in_ep_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'hF2;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       fifo_wr = 1'b0;
    logic [7:0] fifo_wdata = 8'h00;
    logic       tok_in = 1'b0, tx_pop = 1'b0, host_ack = 1'b0, irq_ack = 1'b0;
    logic [1:0] resp;
    logic [7:0] tx_data;
    logic [6:0] tx_len;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference state built from the requirements.
    bit       m_rdy, m_tog, m_stall, m_irq;
    int       m_size, m_cnt, m_rd;
    bit [7:0] m_mem [64];

    always #5 clk = ~clk;

    usb_in_ep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .tok_in(tok_in), .tx_pop(tx_pop),
        .host_ack(host_ack), .resp(resp), .tx_data(tx_data), .tx_len(tx_len),
        .irq_ack(irq_ack), .irq(irq)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len();
        return (m_cnt < m_size * 8) ? m_cnt : m_size * 8;
    endfunction

    function automatic int exp_resp();
        if (m_stall) return 1;
        if (!m_rdy)  return 0;
        return m_tog ? 3 : 2;
    endfunction

    function automatic int exp_rdata();
        if (reg_addr != 8'hF2) return 0;
        return (m_size << 3) | (int'(m_stall) << 1) | int'(m_rdy);
    endfunction

    function automatic int exp_data();
        return (m_rd < exp_len()) ? int'(m_mem[m_rd]) : 0;
    endfunction

    task automatic model_reset();
        m_rdy = 0; m_tog = 0; m_stall = 0; m_irq = 0;
        m_size = 0; m_cnt = 0; m_rd = 0;
    endtask

    // Apply one clock edge to the reference model using the driven inputs.
    task automatic model_step();
        bit wr, ack, fl, pop, push;
        int len;
        wr   = reg_wr && reg_addr == 8'hF2;
        ack  = host_ack && m_rdy && !m_stall;
        fl   = wr && reg_wdata[2];
        len  = exp_len();
        pop  = tx_pop && m_rdy && !m_stall && m_rd < len;
        push = fifo_wr && !m_rdy && m_cnt < 64;
        if (push && !(fl || ack)) m_mem[m_cnt] = fifo_wdata;
        if (fl || ack)  m_cnt = 0; else if (push) m_cnt++;
        if (fl || ack || tok_in) m_rd = 0; else if (pop) m_rd++;
        if (ack) m_irq = 1; else if (irq_ack) m_irq = 0;
        if (wr && reg_wdata[7]) m_tog = 0; else if (ack) m_tog = ~m_tog;
        if (ack || fl) m_rdy = 0; else if (wr && reg_wdata[0]) m_rdy = 1;
        if (wr) begin m_stall = reg_wdata[1]; m_size = int'(reg_wdata[6:3]); end
    endtask

    task automatic compare_all();
        chk("R2 rdata", int'(reg_rdata), exp_rdata());
        chk("R7 resp", int'(resp), exp_resp());
        chk("R9 tx_len", int'(tx_len), exp_len());
        chk("R9 tx_data", int'(tx_data), exp_data());
        chk("R11 irq", int'(irq), int'(m_irq));
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
        reg_wr = 0; fifo_wr = 0; tok_in = 0; tx_pop = 0; host_ack = 0; irq_ack = 0;
        compare_all();
    endtask

    task automatic wreg(logic [7:0] v);
        reg_addr = 8'hF2; reg_wr = 1; reg_wdata = v; step();
    endtask

    task automatic push(logic [7:0] v);
        fifo_wr = 1; fifo_wdata = v; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        @(negedge clk); step(); step();
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", int'(reg_rdata), 0);
        chk("R1 resp", int'(resp), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 tx_len", int'(tx_len), 0);

        // R3 / R9: size 2 -> 16 byte limit, 20 bytes loaded
        wreg(8'h10);
        for (int i = 0; i < 20; i++) push(8'hA0 + 8'(i));
        chk("R9 limited length", int'(tx_len), 16);
        chk("R3 size readback", int'(reg_rdata), 8'h10);
        reg_addr = 8'h33; step();
        chk("R2 other address", int'(reg_rdata), 0);
        reg_addr = 8'hF2;

        // R7: ready with size 15 -> DATA0, full 20 bytes
        wreg(8'h79);
        chk("R7 data0", int'(resp), 2);
        chk("R9 full length", int'(tx_len), 20);
        push(8'h55);
        chk("R10 push ignored when ready", int'(tx_len), 20);

        // R9: token, pops, retry rewind
        tok_in = 1; step();
        for (int i = 0; i < 3; i++) begin tx_pop = 1; step(); end
        chk("R9 pointer byte", int'(tx_data), 8'hA3);
        tok_in = 1; step();
        chk("R9 rewind", int'(tx_data), 8'hA0);

        // R6: stall overrides, ack ignored
        wreg(8'h7B);
        chk("R6 stall resp", int'(resp), 1);
        host_ack = 1; step();
        chk("R6 ack ignored irq", int'(irq), 0);
        chk("R6 ack ignored ready", int'(reg_rdata), 8'h7B);

        // R8 / R11: unstall then ack
        wreg(8'h79);
        host_ack = 1; step();
        chk("R8 ready cleared", int'(resp), 0);
        chk("R8 buffer emptied", int'(tx_len), 0);
        chk("R11 irq set", int'(irq), 1);
        host_ack = 1; step();
        chk("R8 ack when idle ignored", int'(irq), 1);
        push(8'h11); wreg(8'h79);
        chk("R8 toggle flipped", int'(resp), 3);
        wreg(8'hF9);
        chk("R4 toggle cleared", int'(resp), 2);

        // R5: flush with ready set in the same write
        wreg(8'h7D);
        chk("R5 flush wins", int'(reg_rdata), 8'h78);
        chk("R5 buffer empty", int'(tx_len), 0);

        // R11: acknowledge clears
        irq_ack = 1; step();
        chk("R11 irq cleared", int'(irq), 0);

        // Random traffic checked every cycle against the model.
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 12) begin
                reg_addr = ($urandom % 8 == 0) ? 8'($urandom) : 8'hF2;
                reg_wr = 1;
                reg_wdata = 8'($urandom);
                if ($urandom % 4 != 0) reg_wdata[2] = 0;
                if ($urandom % 3 != 0) reg_wdata[1] = 0;
            end else begin
                reg_addr = ($urandom % 10 == 0) ? 8'h00 : 8'hF2;
            end
            fifo_wr    = ($urandom % 3 == 0);
            fifo_wdata = 8'($urandom);
            tok_in     = ($urandom % 10 == 0);
            tx_pop     = ($urandom % 3 == 0);
            host_ack   = ($urandom % 12 == 0);
            irq_ack    = ($urandom % 8 == 0);
            step();
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule